// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Software Staging

This block is a small, fully associative address translation buffer that software maintains by hand. Software fills a set of staging values around the block: a page-size mask, a virtual page tag with an address-space identifier, two physical page descriptors (even page and odd page), a slot index and a replacement slot. It then issues one of four commands. An indexed read copies a stored entry back out into the staging format. An indexed write or a replacement-slot write stores the staged values in a slot. A probe searches all slots at once for a virtual page and address-space match. The block never picks a victim slot itself. The replacement slot number arrives on an input from elsewhere.

Each slot covers a pair of adjacent pages and carries its own page size, taken from the stored mask. On every write the block decodes the mask into a shift amount and an offset mask. It rejects mask patterns that name no legal size. A small-page mode, enabled by two configuration inputs together, permits 1 KB pages. When that mode is off, writes and probes fold the two lowest tag bits away.

A command is a one-cycle strobe with an operation code. Exactly one clock later a one-cycle `done` pulse appears together with the results and flags telling the surrounding logic which staging values to reload. The strobe has no ready signal and no back-pressure: every strobe is accepted, and commands may arrive on consecutive cycles. A command always sees the effect of the command strobed one cycle earlier.

Top module: `tlbv_core`

## Requirements
- R1: Operation codes are 0 indexed read, 1 indexed write, 2 write at replacement slot, 3 probe. `done` is high for exactly the one cycle after each cycle in which `op_go` is high and is low otherwise. `ld_entry` is set only with a read, `ld_index` only with a probe, and `op_err` only with a write.
- R2: A write stores the tag as staged tag bits 31:11 and the identifier as bits 7:0. From each descriptor it stores the frame number (bits 31:6), attribute (bits 5:3), dirty (bit 2) and valid (bit 1). The stored global bit is the AND of bit 0 of both descriptors. A read returns the mask shifted left by 11, the tag shifted left by 11 ORed with the identifier, and each descriptor rebuilt in the same bit layout with the shared global bit in bit 0.
- R3: Small-page mode is on only when `kpage_avail` and `kpage_on` are both 1. When it is off, a write sets the two lowest mask bits and clears the two lowest tag bits. When it is on, both are stored unmodified.
- R4: The stored 18-bit mask (staged bits 28:11) decodes to a shift amount. The first match wins, in this order: low 16 bits equal to 0x3 gives 12; low 16 bits all zero gives 10; then, for k = 1..7, bits 2k+1:2k equal to 11 with bits 15:2k+2 zero gives 12+2k; bits 17:16 equal to 11 gives 28. The reported offset mask is (1 << shift) - 1.
- R5: A write whose mask matches no pattern in R4 raises `op_err` with `done` and leaves every slot unchanged.
- R6: An indexed write or read uses the low 4 bits of the staged index, so bit 31 and the other upper bits have no effect. A replacement write uses `stg_random` as the slot.
- R7: A probe reports the matching slot number, zero-extended, on `res_index`. On a miss it reports 0x8000_0000.
- R8: A probe compares the tag only above the slot's page boundary, skipping tag bits where the slot's mask is 1. It ignores the identifier when the slot's global bit is 1. When small-page mode is off, it clears the probe tag's two lowest bits.
- R9: When several slots match a probe, the lowest slot number is reported.
- R10: After reset every slot holds all-zero fields and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_go | input | 1 | One-cycle command strobe |
| op_code | input | 2 | Command code (R1) |
| kpage_avail | input | 1 | Small pages supported |
| kpage_on | input | 1 | Small pages enabled |
| stg_pgmask | input | 32 | Staged page mask |
| stg_hi | input | 32 | Staged virtual tag and identifier |
| stg_lo0 | input | 32 | Staged even-page descriptor |
| stg_lo1 | input | 32 | Staged odd-page descriptor |
| stg_index | input | 32 | Staged slot index |
| stg_random | input | 4 | Replacement slot |
| done | output | 1 | Command finished pulse |
| op_err | output | 1 | Write rejected for an illegal mask |
| ld_entry | output | 1 | Read results valid for reloading staging |
| ld_index | output | 1 | Probe result valid for reloading staging |
| res_pgmask | output | 32 | Read-back page mask |
| res_hi | output | 32 | Read-back tag and identifier |
| res_lo0 | output | 32 | Read-back even-page descriptor |
| res_lo1 | output | 32 | Read-back odd-page descriptor |
| res_index | output | 32 | Probe result |
| res_shift | output | 5 | Shift amount of the last accepted write |
| res_offmask | output | 32 | Offset mask of the last accepted write |

## Verification
The properties assume that `op_code` and the staging inputs are stable around the clock edge on which `op_go` is sampled, and that the two small-page inputs do not change in the cycle of a strobe. The stimulus keeps to this by changing every input only on the falling clock edge, holding the strobe for exactly one cycle, and switching page mode only between commands. The properties also assume that `op_code` always carries one of the four defined codes, which a 2-bit field guarantees.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
  localparam int REG_W    = 32;
  localparam int MASK_W   = 18;
  localparam int VPN_W    = 21;
  localparam int PFN_W    = 26;
  localparam int ASID_W   = 8;
  localparam int ATTR_W   = 3;
  localparam int SHIFT_W  = 5;
  localparam int PG_LSB   = 11;
  localparam int PFN_LSB  = 6;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WR_IDX = 2'd1,
    OP_WR_RND = 2'd2,
    OP_PROBE  = 2'd3
  } tlbv_op_e;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } tlbv_half_t;

  typedef struct packed {
    logic [MASK_W-1:0]  mask;
    logic [VPN_W-1:0]   vpn;
    logic [ASID_W-1:0]  asid;
    logic               glob;
    tlbv_half_t         even;
    tlbv_half_t         odd;
    logic [SHIFT_W-1:0] shift;
  } tlbv_entry_t;

  function automatic tlbv_half_t half_from_reg(input logic [REG_W-1:0] r);
    tlbv_half_t h;
    h.pfn   = r[PFN_LSB +: PFN_W];
    h.attr  = r[3 +: ATTR_W];
    h.dirty = r[2];
    h.valid = r[1];
    return h;
  endfunction

  function automatic logic [REG_W-1:0] half_to_reg(input tlbv_half_t h, input logic g);
    return {h.pfn, h.attr, h.dirty, h.valid, g};
  endfunction
endpackage

// File: rtl/tlbv_size_dec.sv
module tlbv_size_dec
  import tlbv_pkg::*;
(
  input  logic [MASK_W-1:0]  mask,
  output logic               ok,
  output logic [SHIFT_W-1:0] shift,
  output logic [REG_W-1:0]   offmask
);
  localparam int LOW_W     = MASK_W - 2;
  localparam int NB        = MASK_W / 2 - 1;
  localparam int SHIFT_MIN = 10;
  localparam int SHIFT_STD = 12;

  logic [NB:1] band_hit;

  for (genvar p = 1; p <= NB; p++) begin : g_band
    localparam logic [MASK_W-1:0] PAT = MASK_W'(3) << (2 * p);
    localparam logic [MASK_W-1:0] SEL = (p == NB) ? PAT
                                      : (MASK_W'((1 << LOW_W) - 1) & ~(MASK_W'((1 << (2 * p)) - 1)));
    assign band_hit[p] = ((mask & SEL) == PAT);
  end

  // later assignments carry higher priority
  always_comb begin
    ok    = 1'b0;
    shift = '0;
    for (int p = NB; p >= 1; p--) begin
      if (band_hit[p]) begin
        ok    = 1'b1;
        shift = SHIFT_W'(SHIFT_STD + 2 * p);
      end
    end
    if (mask[LOW_W-1:0] == '0) begin
      ok    = 1'b1;
      shift = SHIFT_W'(SHIFT_MIN);
    end
    if (mask[LOW_W-1:0] == LOW_W'(3)) begin
      ok    = 1'b1;
      shift = SHIFT_W'(SHIFT_STD);
    end
  end

  assign offmask = (REG_W'(1) << shift) - REG_W'(1);
endmodule

// File: rtl/tlbv_store.sv
module tlbv_store
  import tlbv_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  tlbv_entry_t       wdata,
  output tlbv_entry_t       ents [ENTRIES]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
    end else if (we) begin
      ents[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/tlbv_probe.sv
module tlbv_probe
  import tlbv_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tlbv_entry_t        ents [ENTRIES],
  input  logic [VPN_W-1:0]   pvpn,
  input  logic [ASID_W-1:0]  pasid,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] ign;
    logic             tag_eq;
    logic             id_eq;
    assign ign    = VPN_W'(ents[i].mask);
    assign tag_eq = (((ents[i].vpn ^ pvpn) & ~ign) == '0);
    assign id_eq  = ents[i].glob || (ents[i].asid == pasid);
    assign match[i] = tag_eq && id_eq;
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlbv_core.sv
module tlbv_core
  import tlbv_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_go,
  input  logic [1:0]         op_code,
  input  logic               kpage_avail,
  input  logic               kpage_on,
  input  logic [REG_W-1:0]   stg_pgmask,
  input  logic [REG_W-1:0]   stg_hi,
  input  logic [REG_W-1:0]   stg_lo0,
  input  logic [REG_W-1:0]   stg_lo1,
  input  logic [REG_W-1:0]   stg_index,
  input  logic [IDX_W-1:0]   stg_random,
  output logic               done,
  output logic               op_err,
  output logic               ld_entry,
  output logic               ld_index,
  output logic [REG_W-1:0]   res_pgmask,
  output logic [REG_W-1:0]   res_hi,
  output logic [REG_W-1:0]   res_lo0,
  output logic [REG_W-1:0]   res_lo1,
  output logic [REG_W-1:0]   res_index,
  output logic [SHIFT_W-1:0] res_shift,
  output logic [REG_W-1:0]   res_offmask
);
  localparam logic [REG_W-1:0] MISS_CODE = REG_W'(1) << (REG_W - 1);

  tlbv_op_e            op;
  logic                small_pg;
  logic [MASK_W-1:0]   new_mask;
  logic [VPN_W-1:0]    new_vpn;
  logic                sz_ok;
  logic [SHIFT_W-1:0]  sz_shift;
  logic [REG_W-1:0]    sz_off;
  tlbv_entry_t         new_ent;
  tlbv_entry_t         ents [ENTRIES];
  tlbv_entry_t         rd_ent;
  logic                is_wr;
  logic                we;
  logic [IDX_W-1:0]    waddr;
  logic                p_hit;
  logic [IDX_W-1:0]    p_idx;

  assign op       = tlbv_op_e'(op_code);
  assign small_pg = kpage_avail && kpage_on;

  // staged values with the small-page folding applied
  always_comb begin
    new_mask = stg_pgmask[PG_LSB +: MASK_W];
    new_vpn  = stg_hi[PG_LSB +: VPN_W];
    if (!small_pg) begin
      new_mask[1:0] = 2'b11;
      new_vpn[1:0]  = 2'b00;
    end
  end

  tlbv_size_dec u_size (
    .mask    (new_mask),
    .ok      (sz_ok),
    .shift   (sz_shift),
    .offmask (sz_off)
  );

  always_comb begin
    new_ent.mask  = new_mask;
    new_ent.vpn   = new_vpn;
    new_ent.asid  = stg_hi[ASID_W-1:0];
    new_ent.glob  = stg_lo0[0] & stg_lo1[0];
    new_ent.even  = half_from_reg(stg_lo0);
    new_ent.odd   = half_from_reg(stg_lo1);
    new_ent.shift = sz_shift;
  end

  assign is_wr = op_go && (op == OP_WR_IDX || op == OP_WR_RND);
  assign we    = is_wr && sz_ok;
  assign waddr = (op == OP_WR_RND) ? stg_random : stg_index[IDX_W-1:0];

  tlbv_store #(.ENTRIES(ENTRIES)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (waddr),
    .wdata (new_ent),
    .ents  (ents)
  );

  tlbv_probe #(.ENTRIES(ENTRIES)) u_probe (
    .ents    (ents),
    .pvpn    (new_vpn),
    .pasid   (stg_hi[ASID_W-1:0]),
    .hit     (p_hit),
    .hit_idx (p_idx)
  );

  assign rd_ent = ents[stg_index[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      op_err      <= 1'b0;
      ld_entry    <= 1'b0;
      ld_index    <= 1'b0;
      res_pgmask  <= '0;
      res_hi      <= '0;
      res_lo0     <= '0;
      res_lo1     <= '0;
      res_index   <= '0;
      res_shift   <= '0;
      res_offmask <= '0;
    end else begin
      done     <= op_go;
      op_err   <= 1'b0;
      ld_entry <= 1'b0;
      ld_index <= 1'b0;
      if (op_go) begin
        unique case (op)
          OP_READ: begin
            ld_entry   <= 1'b1;
            res_pgmask <= REG_W'(rd_ent.mask) << PG_LSB;
            res_hi     <= (REG_W'(rd_ent.vpn) << PG_LSB) | REG_W'(rd_ent.asid);
            res_lo0    <= half_to_reg(rd_ent.even, rd_ent.glob);
            res_lo1    <= half_to_reg(rd_ent.odd, rd_ent.glob);
          end
          OP_WR_IDX, OP_WR_RND: begin
            op_err <= !sz_ok;
            if (sz_ok) begin
              res_shift   <= sz_shift;
              res_offmask <= sz_off;
            end
          end
          OP_PROBE: begin
            ld_index  <= 1'b1;
            res_index <= p_hit ? REG_W'(p_idx) : MISS_CODE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlbv_chk.sv
module tlbv_chk #(
  parameter int IDX_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_go,
  input logic [1:0]  op_code,
  input logic        done,
  input logic        op_err,
  input logic        ld_entry,
  input logic        ld_index,
  input logic [31:0] res_index,
  input logic [4:0]  res_shift,
  input logic [31:0] res_offmask
);
  // R1
  done_follows_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |=> done);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_go |=> !done);
  // R1
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_entry, ld_index, op_err}));
  // R1
  probe_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go && op_code == 2'd3 |=> ld_index);
  // R5
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> done);
  // R7
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_index && res_index[31]) |-> (res_index[30:0] == '0));
  // R7
  hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_index && !res_index[31]) |-> ((res_index >> IDX_W) == '0));
  // R4
  shift_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ld_entry && !ld_index && !op_err) |->
      (res_shift >= 5'd10 && res_shift <= 5'd28 && !res_shift[0]
       && $countones(res_offmask) == 32'(res_shift)));
endmodule

bind tlbv_core tlbv_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_go       (op_go),
  .op_code     (op_code),
  .done        (done),
  .op_err      (op_err),
  .ld_entry    (ld_entry),
  .ld_index    (ld_index),
  .res_index   (res_index),
  .res_shift   (res_shift),
  .res_offmask (res_offmask)
);

// File: tb/sim_tlbv_core.sv
module sim_tlbv_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_go = 1'b0;
  logic [1:0]  op_code = 2'd0;
  logic        kpage_avail = 1'b0;
  logic        kpage_on = 1'b0;
  logic [31:0] stg_pgmask = '0, stg_hi = '0, stg_lo0 = '0, stg_lo1 = '0, stg_index = '0;
  logic [3:0]  stg_random = '0;
  logic        done, op_err, ld_entry, ld_index;
  logic [31:0] res_pgmask, res_hi, res_lo0, res_lo1, res_index, res_offmask;
  logic [4:0]  res_shift;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tlbv_core u0 (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
    .kpage_avail(kpage_avail), .kpage_on(kpage_on),
    .stg_pgmask(stg_pgmask), .stg_hi(stg_hi), .stg_lo0(stg_lo0), .stg_lo1(stg_lo1),
    .stg_index(stg_index), .stg_random(stg_random),
    .done(done), .op_err(op_err), .ld_entry(ld_entry), .ld_index(ld_index),
    .res_pgmask(res_pgmask), .res_hi(res_hi), .res_lo0(res_lo0), .res_lo1(res_lo1),
    .res_index(res_index), .res_shift(res_shift), .res_offmask(res_offmask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(input logic [20:0] vpn, input logic [7:0] asid);
    return ({11'd0, vpn} << 11) | {24'd0, asid};
  endfunction

  // strobe for one cycle; outputs of the command are stable on return
  task automatic run_op(input logic [1:0] c);
    @(negedge clk);
    op_code = c;
    op_go   = 1'b1;
    @(negedge clk);
    op_go   = 1'b0;
  endtask

  task automatic wr(input logic [3:0] slot, input logic [31:0] pg, input logic [31:0] hi,
                    input logic [31:0] l0, input logic [31:0] l1);
    stg_index = {28'd0, slot}; stg_pgmask = pg; stg_hi = hi; stg_lo0 = l0; stg_lo1 = l1;
    run_op(2'd1);
  endtask

  task automatic rd(input logic [31:0] idx);
    stg_index = idx;
    run_op(2'd0);
  endtask

  task automatic probe(input logic [31:0] hi);
    stg_hi = hi;
    run_op(2'd3);
  endtask

  task automatic t_reset;
    chk("R10 done", {31'd0, done}, 0);
    chk("R10 res_index", res_index, 0);
    rd(32'd5);
    chk("R10 read hi", res_hi, 0);
    chk("R10 read lo0", res_lo0, 0);
    chk("R1 ld_entry on read", {31'd0, ld_entry}, 1);
    probe(32'd0);
    chk("R9 all-zero slots lowest", res_index, 0);
    chk("R1 done pulse", {31'd0, done}, 1);
    @(negedge clk);
    chk("R1 done clears", {31'd0, done}, 0);
  endtask

  task automatic t_write_read;
    logic [31:0] hi = 32'h1234_5F7B;
    logic [31:0] l0 = 32'hABCD_E5A7;
    logic [31:0] l1 = 32'h1357_9BDE;
    logic [31:0] pg = 32'h0000_0000;
    wr(4'd3, pg, hi, l0, l1);
    chk("R1 no err", {31'd0, op_err}, 0);
    chk("R4 shift 4k", {27'd0, res_shift}, 12);
    chk("R4 offmask 4k", res_offmask, 32'h0000_0FFF);
    rd(32'h8000_0003);
    chk("R3 mask forced", res_pgmask, 32'h3 << 11);
    chk("R3 vpn low cleared", res_hi, ((hi >> 11) & ~32'h3) << 11 | {24'd0, hi[7:0]});
    chk("R2 lo0 rebuilt", res_lo0, {l0[31:1], l0[0] & l1[0]});
    chk("R2 lo1 rebuilt", res_lo1, {l1[31:1], l0[0] & l1[0]});
  endtask

  task automatic t_sizes;
    wr(4'd4, 32'hC << 11, mk_hi(21'h100, 8'h1), 0, 0);
    chk("R4 16k", {27'd0, res_shift}, 14);
    wr(4'd4, 32'h3FFFF << 11, mk_hi(21'h100, 8'h1), 0, 0);
    chk("R4 band priority", {27'd0, res_shift}, 26);
    wr(4'd4, 32'h30000 << 11, mk_hi(21'h100, 8'h1), 0, 0);
    chk("R4 low pattern first", {27'd0, res_shift}, 12);
    kpage_avail = 1'b1; kpage_on = 1'b1;
    wr(4'd4, 32'h0, mk_hi(21'h101, 8'h1), 0, 0);
    chk("R4 1k shift", {27'd0, res_shift}, 10);
    chk("R4 1k offmask", res_offmask, 32'h3FF);
    rd(32'd4);
    chk("R3 1k keeps vpn", res_hi, mk_hi(21'h101, 8'h1));
    chk("R3 1k keeps mask", res_pgmask, 0);
    wr(4'd4, 32'h30 << 11, mk_hi(21'h100, 8'h1), 0, 0);
    chk("R4 64k", {27'd0, res_shift}, 16);
    kpage_on = 1'b0;
  endtask

  task automatic t_invalid;
    wr(4'd7, 0, mk_hi(21'h2220, 8'h5), 32'h40, 32'h80);
    kpage_on = 1'b1;
    wr(4'd7, 32'h5 << 11, mk_hi(21'h3330, 8'h6), 0, 0);
    chk("R5 err raised", {31'd0, op_err}, 1);
    kpage_on = 1'b0;
    rd(32'd7);
    chk("R5 slot kept", res_hi, mk_hi(21'h2220, 8'h5));
    chk("R5 lo kept", res_lo0, 32'h40);
  endtask

  task automatic t_random;
    stg_random = 4'd9;
    stg_index  = 32'd2;
    stg_pgmask = 0; stg_hi = mk_hi(21'h4440, 8'h9); stg_lo0 = 32'h1C0; stg_lo1 = 0;
    run_op(2'd2);
    rd(32'd9);
    chk("R6 random slot", res_hi, mk_hi(21'h4440, 8'h9));
    rd(32'hFFFF_FFF2);
    chk("R6 index slot untouched", res_hi, 0);
  endtask

  task automatic t_probe;
    wr(4'd10, 0, mk_hi(21'h01230, 8'h11), 0, 0);
    probe(mk_hi(21'h01230, 8'h22));
    chk("R7 miss", res_index, 32'h8000_0000);
    probe(mk_hi(21'h01230, 8'h11));
    chk("R7 hit", res_index, 10);
    wr(4'd11, 0, mk_hi(21'h04560, 8'h33), 1, 1);
    probe(mk_hi(21'h04560, 8'h44));
    chk("R8 global ignores id", res_index, 11);
    wr(4'd12, 32'hC << 11, mk_hi(21'h07890, 8'h1), 0, 0);
    probe(mk_hi(21'h07896, 8'h1));
    chk("R8 page boundary", res_index, 12);
    probe(mk_hi(21'h07891, 8'h2));
    chk("R8 id mismatch", res_index, 32'h8000_0000);
    wr(4'd14, 0, mk_hi(21'h0ABC0, 8'h7), 0, 0);
    wr(4'd13, 0, mk_hi(21'h0ABC0, 8'h7), 0, 0);
    probe(mk_hi(21'h0ABC2, 8'h7));
    chk("R9 lowest wins", res_index, 13);
    kpage_on = 1'b1;
    wr(4'd15, 0, mk_hi(21'h0DEF1, 8'h3), 0, 0);
    probe(mk_hi(21'h0DEF0, 8'h3));
    chk("R8 1k exact miss", res_index, 32'h8000_0000);
    probe(mk_hi(21'h0DEF1, 8'h3));
    chk("R8 1k exact hit", res_index, 15);
    kpage_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_sizes();
    t_invalid();
    t_random();
    t_probe();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule